// File: doc/BRIEF.md
# Fixed-point power sequencer on a shared hyperbolic CORDIC

The block raises a positive fixed-point operand x to a fixed-point power y. It does this with one iterative hyperbolic CORDIC core that it runs twice. The first run is in vectoring mode and yields half the natural logarithm of x. The sequencer doubles that value and multiplies it by y. The second run is in rotation mode and exponentiates the product, so the result is exp(y·ln x).

Both operands arrive on valid/ready streams. The x stream is accepted only while the block is idle. The y stream is accepted only once the logarithm pass is over, so a producer may present y early and simply be held off. A producer may also present y late, and the block stalls in its wait state until it does. The result leaves with a single-cycle done pulse and has no back-pressure: the consumer must capture `result` and `err` in the cycle `done` is high. A non-positive x is not processed. It is reported at once through `err`, and no y is taken for that operation.

Top module: `pw_power`

## Requirements
- R1: `x_ready` is high exactly when the block is idle. An x is taken on a cycle where `x_valid` and `x_ready` are both high. Once x is taken, `x_ready` stays low and `x_valid` is ignored until the operation ends.
- R2: A non-error operation uses exactly two core passes. The first is vectoring with inputs x+1, x−1 and 0, and its angle output is doubled by a one-bit left shift to give ln x. The second is rotation with both vector inputs set to the inverse core gain and the angle input set to the scaled product.
- R3: `y_ready` rises only after the logarithm pass has finished, which is at least N plus the number of repeated iterations cycles after x is taken. A `y_valid` held high before that is not consumed. While `y_ready` is high and `y_valid` is low, the block waits and `done` stays low.
- R4: The product y·ln x is formed at double width, shifted right by F bits, and saturated to the largest or smallest W-bit value on overflow. A saturated positive argument therefore gives exp(θmax) and a saturated negative one gives exp(−θmax), where θmax is the sum of the iteration angles.
- R5: Operands and result are two's-complement numbers with W bits, F of them fractional. For 0.2 ≤ x ≤ 8 and |y·ln x| ≤ 1, `result` equals x^y within the rounding error of the iterations.
- R6: If x ≤ 0 (sign bit set or all zero), `done` and `err` are high in the cycle after x is taken. No core pass is started, `y_ready` never rises, and `result` reads zero.
- R7: `done` is high for one cycle per operation, and `err` is high only while `done` is high.
- R8: After reset, `x_ready` is 1 and `y_ready`, `done` and `err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| x_valid | input | 1 | Base operand valid |
| x_ready | output | 1 | Base operand accepted this cycle when valid |
| x_data | input | W | Base operand x, signed fixed point |
| y_valid | input | 1 | Exponent operand valid |
| y_ready | output | 1 | Exponent accepted this cycle when valid |
| y_data | input | W | Exponent operand y, signed fixed point |
| done | output | 1 | One-cycle result strobe |
| err | output | 1 | With done: x was not positive |
| result | output | W | x^y, signed fixed point, valid with done |

## Verification
The bench builds the block with W=32, F=20 and N=20, so iterations 4 and 13 are repeated and each pass takes 22 steps. With 11 integer bits, the scaled product overflows once |y·ln x| reaches 2048. Moderate exponents such as ±2000 on x=4 therefore reach both saturation limits. A wrap-around in place of saturation would flip the result between exp(θmax) and exp(−θmax). The 20 fractional bits keep the iteration error small enough that random bases over the whole convergence range can be checked against exp(y·ln x) with a tight tolerance.

// File: rtl/pw_pkg.sv
package pw_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_LOAD_V, S_WAIT_V, S_SCALE, S_WAIT_Y,
    S_MUL, S_LOAD_R, S_WAIT_R, S_DONE
  } pw_state_e;

  typedef enum logic {CM_ROTATE = 1'b0, CM_VECTOR = 1'b1} cmode_e;

  // hyperbolic iterations 4, 13, 40, ... run twice for convergence
  function automatic bit is_repeat(int i);
    for (int r = 4; r <= i; r = 3 * r + 1)
      if (r == i) return 1'b1;
    return 1'b0;
  endfunction

  // atanh(2^-i) in fixed point with f fractional bits, series sum
  function automatic logic [63:0] atanh_fx(int i, int f);
    logic [63:0] acc;
    int e;
    acc = '0;
    for (int k = 0; k < 32; k++) begin
      e = 62 - i * (2 * k + 1);
      if (e >= 0) acc = acc + ((64'd1 << e) / 64'(2 * k + 1));
    end
    return (acc + (64'd1 << (61 - f))) >> (62 - f);
  endfunction

  // inverse of the hyperbolic gain over n iterations incl. repeats
  function automatic logic [63:0] inv_gain_fx(int n, int f);
    logic [63:0]  p;
    logic [63:0]  r;
    logic [63:0]  t;
    logic [127:0] q;
    p = 64'd1 << 62;
    for (int i = 1; i <= n; i++) begin
      p = p - (p >> (2 * i));
      if (is_repeat(i)) p = p - (p >> (2 * i));
    end
    r = '0;
    for (int b = 31; b >= 0; b--) begin
      t = r | (64'd1 << b);
      if (t * t <= p) r = t;
    end
    q = (128'd1 << (f + 31)) / {64'd0, r};
    return q[63:0];
  endfunction

endpackage

// File: rtl/pw_cordic.sv
module pw_cordic
  import pw_pkg::*;
#(
  parameter int W = 32,
  parameter int F = 20,
  parameter int N = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  cmode_e              mode,
  input  logic signed [W-1:0] x0,
  input  logic signed [W-1:0] y0,
  input  logic signed [W-1:0] z0,
  output logic                busy,
  output logic                done,
  output logic signed [W-1:0] xo,
  output logic signed [W-1:0] zo
);
  localparam int IW = $clog2(N + 2);

  logic signed [W-1:0] theta [N+1];
  logic [N:0]          rep;

  assign theta[0] = '0;
  assign rep[0]   = 1'b0;
  for (genvar g = 1; g <= N; g++) begin : g_tab
    assign theta[g] = W'(atanh_fx(g, F));
    assign rep[g]   = is_repeat(g);
  end

  logic signed [W-1:0] xr, yr, zr, th, xs, ys, xn, yn, zn;
  logic [IW-1:0]       idx;
  logic                again, dneg, hold, last;
  cmode_e              mode_q;

  always_comb begin
    th   = theta[idx];
    // rotation drives z to zero, vectoring drives y to zero
    dneg = (mode_q == CM_ROTATE) ? zr[W-1] : !yr[W-1];
    xs   = yr >>> idx;
    ys   = xr >>> idx;
    xn   = dneg ? xr - xs : xr + xs;
    yn   = dneg ? yr - ys : yr + ys;
    zn   = dneg ? zr + th : zr - th;
    hold = rep[idx] && !again;
    last = (idx == IW'(N)) && !hold;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xr <= '0; yr <= '0; zr <= '0;
      idx <= '0; again <= 1'b0; busy <= 1'b0; done <= 1'b0;
      mode_q <= CM_ROTATE;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        xr <= x0; yr <= y0; zr <= z0;
        mode_q <= mode;
        idx <= IW'(1);
        again <= 1'b0;
        busy <= 1'b1;
      end else if (busy) begin
        xr <= xn; yr <= yn; zr <= zn;
        if (hold) begin
          again <= 1'b1;
        end else begin
          again <= 1'b0;
          idx <= idx + 1'b1;
        end
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign xo = xr;
  assign zo = zr;
endmodule

// File: rtl/pw_mulsat.sv
module pw_mulsat #(
  parameter int W = 32,
  parameter int F = 20
) (
  input  logic signed [W-1:0] a,
  input  logic signed [W-1:0] b,
  output logic signed [W-1:0] p
);
  localparam int PW = 2 * W;

  logic signed [PW-1:0] full, sh, hi_lim, lo_lim;

  always_comb begin
    full   = PW'(a) * PW'(b);
    sh     = full >>> F;
    hi_lim = {{(W + 1){1'b0}}, {(W - 1){1'b1}}};
    lo_lim = {{(W + 1){1'b1}}, {(W - 1){1'b0}}};
    if (sh > hi_lim)      p = hi_lim[W-1:0];
    else if (sh < lo_lim) p = lo_lim[W-1:0];
    else                  p = sh[W-1:0];
  end
endmodule

// File: rtl/pw_power.sv
module pw_power
  import pw_pkg::*;
#(
  parameter int W = 32,
  parameter int F = 20,
  parameter int N = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                x_valid,
  output logic                x_ready,
  input  logic signed [W-1:0] x_data,
  input  logic                y_valid,
  output logic                y_ready,
  input  logic signed [W-1:0] y_data,
  output logic                done,
  output logic                err,
  output logic signed [W-1:0] result
);
  localparam logic signed [W-1:0] K_INV = W'(inv_gain_fx(N, F));
  localparam logic signed [W-1:0] ONE   = W'(64'd1 << F);

  pw_state_e           st;
  logic signed [W-1:0] xq, yq, lnq, zarg, res, prod;
  logic                err_q;

  logic                c_start, c_busy, c_done;
  cmode_e              c_mode;
  logic signed [W-1:0] c_x0, c_y0, c_z0, c_xo, c_zo;

  always_comb begin
    c_start = (st == S_LOAD_V) || (st == S_LOAD_R);
    c_mode  = (st == S_LOAD_V) ? CM_VECTOR : CM_ROTATE;
    c_x0    = (c_mode == CM_VECTOR) ? xq + ONE : K_INV;
    c_y0    = (c_mode == CM_VECTOR) ? xq - ONE : K_INV;
    c_z0    = (c_mode == CM_VECTOR) ? '0 : zarg;
  end

  pw_cordic #(.W(W), .F(F), .N(N)) u_core (
    .clk(clk), .rst_n(rst_n), .start(c_start), .mode(c_mode),
    .x0(c_x0), .y0(c_y0), .z0(c_z0),
    .busy(c_busy), .done(c_done), .xo(c_xo), .zo(c_zo)
  );

  pw_mulsat #(.W(W), .F(F)) u_mul (.a(lnq), .b(yq), .p(prod));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      xq <= '0; yq <= '0; lnq <= '0; zarg <= '0; res <= '0;
      err_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (x_valid) begin
          xq    <= x_data;
          err_q <= x_data[W-1] || (x_data == '0);
          if (x_data[W-1] || (x_data == '0)) begin
            res <= '0;
            st  <= S_DONE;
          end else begin
            st <= S_LOAD_V;
          end
        end
        S_LOAD_V: st <= S_WAIT_V;
        S_WAIT_V: if (c_done) begin
          lnq <= c_zo;
          st  <= S_SCALE;
        end
        S_SCALE: begin
          lnq <= lnq <<< 1;
          st  <= S_WAIT_Y;
        end
        S_WAIT_Y: if (y_valid) begin
          yq <= y_data;
          st <= S_MUL;
        end
        S_MUL: begin
          zarg <= prod;
          st   <= S_LOAD_R;
        end
        S_LOAD_R: st <= S_WAIT_R;
        S_WAIT_R: if (c_done) begin
          res <= c_xo;
          st  <= S_DONE;
        end
        S_DONE:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign x_ready = (st == S_IDLE);
  assign y_ready = (st == S_WAIT_Y);
  assign done    = (st == S_DONE);
  assign err     = done && err_q;
  assign result  = res;
endmodule

// File: rtl/pw_power_chk.sv
module pw_power_chk (
  input logic clk,
  input logic rst_n,
  input logic x_valid,
  input logic x_ready,
  input logic y_ready,
  input logic done,
  input logic err,
  input logic c_start,
  input logic c_busy
);
  logic [1:0] npass;

  always_ff @(posedge clk) begin
    if (!rst_n)                       npass <= '0;
    else if (x_valid && x_ready)      npass <= '0;
    else if (c_start && npass != 2'd3) npass <= npass + 2'd1;
  end

  p_one_op_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (x_valid && x_ready) |=> !x_ready);

  p_y_after_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    y_ready |-> (!c_busy && npass == 2'd1));

  p_two_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> npass == 2'd2);

  p_no_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> npass == 2'd0);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_err_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);
endmodule

bind pw_power pw_power_chk u_chk (
  .clk(clk), .rst_n(rst_n), .x_valid(x_valid), .x_ready(x_ready),
  .y_ready(y_ready), .done(done), .err(err),
  .c_start(c_start), .c_busy(c_busy)
);

// File: tb/pw_power_tb.sv
module pw_power_tb;
  localparam int  W = 32;
  localparam int  F = 20;
  localparam int  N = 20;
  localparam int  CLK_PERIOD = 10;
  localparam int  STEPS = N + ((N >= 4) ? 1 : 0) + ((N >= 13) ? 1 : 0) + ((N >= 40) ? 1 : 0);
  localparam real SC = 2.0 ** F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic x_valid = 1'b0, y_valid = 1'b0;
  logic signed [W-1:0] x_data = '0, y_data = '0;
  logic x_ready, y_ready, done, err;
  logic signed [W-1:0] result;

  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pw_power #(.W(W), .F(F), .N(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .x_valid(x_valid), .x_ready(x_ready),
    .x_data(x_data), .y_valid(y_valid), .y_ready(y_ready), .y_data(y_data),
    .done(done), .err(err), .result(result)
  );

  function automatic logic signed [W-1:0] to_fx(real r);
    return W'($rtoi(r * SC + ((r >= 0.0) ? 0.5 : -0.5)));
  endfunction

  function automatic real from_fx(logic signed [W-1:0] v);
    return real'(v) / SC;
  endfunction

  function automatic real theta_max();
    real s = 0.0;
    for (int i = 1; i <= N; i++) begin
      real t = 2.0 ** (-i);
      real a = 0.5 * $ln((1.0 + t) / (1.0 - t));
      s = s + a;
      if (i == 4 || i == 13 || i == 40) s = s + a;
    end
    return s;
  endfunction

  task automatic chk_int(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_real(string req, real act, real exp, real tol);
    real d = act - exp;
    total++;
    if (d > tol || d < -tol) begin
      bad++;
      $display("FAIL %s: actual=%f expected=%f", req, act, exp);
    end
  endtask

  task automatic run_op(input real xr, input real yr, input bit early,
                        input bit noisy, input int ydly,
                        output real r, output bit e, output int ywait);
    @(negedge clk);
    x_data  = to_fx(xr);
    x_valid = 1'b1;
    if (early) begin
      y_valid = 1'b1;
      y_data  = to_fx(yr);
    end
    @(negedge clk);
    x_valid = noisy;
    if (noisy) x_data = to_fx(0.5);
    chk_int("R1 x_ready low after accept", x_ready, 0);
    ywait = 0;
    while (!y_ready && !done) begin
      @(negedge clk);
      ywait++;
    end
    if (!done) begin
      if (!early) begin
        for (int k = 0; k < ydly; k++) begin
          @(negedge clk);
          chk_int("R3 stall keeps done low", done, 0);
          chk_int("R3 stall keeps y_ready", y_ready, 1);
        end
        y_data  = to_fx(yr);
        y_valid = 1'b1;
      end
      @(negedge clk);
      y_valid = 1'b0;
      chk_int("R3 y_ready drops after take", y_ready, 0);
      while (!done) @(negedge clk);
    end
    x_valid = 1'b0;
    y_valid = 1'b0;
    e = err;
    r = from_fx(result);
    @(negedge clk);
    chk_int("R7 done is one cycle", done, 0);
    chk_int("R7 err only with done", err, 0);
  endtask

  task automatic pow_case(real xr, real yr, bit early, bit noisy, int ydly);
    real r, xq, yq, ex, tol;
    bit  e;
    int  w;
    xq = from_fx(to_fx(xr));
    yq = from_fx(to_fx(yr));
    run_op(xr, yr, early, noisy, ydly, r, e, w);
    ex  = $exp(yq * $ln(xq));
    tol = (5.0e-4 + 1.0e-4 * ((yq < 0.0) ? -yq : yq)) * (1.0 + ex);
    chk_int("R6 no err on positive x", e, 0);
    total++;
    if (w < STEPS + 1) begin
      bad++;
      $display("FAIL R3 y_ready too early: actual=%0d expected>=%0d", w, STEPS + 1);
    end
    chk_real("R5 result equals x^y", r, ex, tol);
  endtask

  task automatic sat_case(real xr, real yr, real ex);
    real r;
    bit  e;
    int  w;
    run_op(xr, yr, 1'b0, 1'b0, 0, r, e, w);
    chk_int("R4 no err", e, 0);
    chk_real("R4 saturated product", r, ex, 2.0e-3);
  endtask

  task automatic err_case(real xr);
    real r;
    bit  e;
    int  w;
    run_op(xr, 1.0, 1'b1, 1'b0, 0, r, e, w);
    chk_int("R6 err raised", e, 1);
    chk_int("R6 done one cycle after accept", w, 0);
    chk_real("R6 result zero", r, 0.0, 0.0);
    chk_int("R6 y not requested", y_ready, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    int seed;
    seed = $urandom(32'd9173);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_int("R8 reset x_ready", x_ready, 1);
    chk_int("R8 reset y_ready", y_ready, 0);
    chk_int("R8 reset done", done, 0);
    chk_int("R8 reset err", err, 0);

    // directed corners
    pow_case(4.0, 0.5, 1'b0, 1'b0, 0);
    pow_case(2.0, -1.0, 1'b1, 1'b0, 0);
    pow_case(1.0, 37.0, 1'b0, 1'b1, 3);
    pow_case(0.25, 0.5, 1'b0, 1'b0, 2);
    pow_case(8.0, 0.4, 1'b0, 1'b1, 0);
    pow_case(0.2, -0.6, 1'b1, 1'b1, 0);
    err_case(0.0);
    err_case(-3.0);
    pow_case(3.0, 0.7, 1'b0, 1'b0, 1);
    sat_case(4.0, 2000.0, $exp(theta_max()));
    sat_case(4.0, -2000.0, $exp(-theta_max()));
    sat_case(0.25, 1600.0, $exp(-theta_max()));

    // constrained random
    for (int n = 0; n < 150; n++) begin
      real xr, l, lim, u;
      xr  = 0.2 + 7.8 * real'($urandom % 10000) / 10000.0;
      l   = $ln(xr);
      lim = (l > 0.01 || l < -0.01) ? 1.0 / ((l < 0.0) ? -l : l) : 100.0;
      u   = (real'($urandom % 20001) - 10000.0) / 10000.0;
      pow_case(xr, u * lim, 1'(($urandom % 4) == 0), 1'($urandom % 2), int'($urandom % 4));
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule